// File: doc/BRIEF.md
# NRZI Bit-Stuffing Line Encoder

This block is the transmit end of a differential packet serial link. It takes packet bits one at a time through a valid/ready handshake. The upstream side marks the first bit with a start flag and the final bit with a last flag. The block frames and line-codes those bits onto a pair of logic-level outputs, `dPlus` and `dMinus`. One clock cycle is one bit time.

A packet opens with a synchronisation pattern: SYNC_LEN-1 zero bits and then a single one bit. The packet bits follow. The line code is NRZI. A zero bit flips the line between the J state (`dPlus`=1, `dMinus`=0) and the K state (`dPlus`=0, `dMinus`=1), and a one bit leaves the line where it is. A long string of ones would give no edges, so an extra zero is forced onto the line whenever STUFF_RUN ones in a row have been sent. That count includes the closing one of the sync pattern, and the forced zero is NRZI-coded like any other zero. During the forced zero the handshake is paused. At the end of the packet, both outputs are held low for EOP_LEN bit times. The line then returns to J for GAP_LEN bit times before another packet may start. Between packets the line rests at J.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: During reset and while no packet is in progress, the line is J: `dPlus`=1 and `dMinus`=0.
- R2: When `inValid` and `inStart` are high with the block idle, the first packet bit is held and not accepted. `inReady` stays low for the idle cycle plus the SYNC_LEN sync cycles, which is 9 cycles by default. The line first shows SYNC_LEN-1 (7) flips and then one bit time with no change.
- R3: Each accepted packet bit takes one bit time on the line. A 0 flips the line between J (10) and K (01), and a 1 holds it. Bits are taken in handshake order.
- R4: Once STUFF_RUN (6) ones in a row have been sent, one extra zero (a line flip) is sent next. The run counts the final sync one. The run restarts at zero after any zero, whether data or stuffed, so the run count never exceeds STUFF_RUN.
- R5: `inReady` is low in the bit time that carries a stuffed zero, and no packet bit is lost or repeated.
- R6: If the bit flagged `inLast` completes a run of STUFF_RUN ones, the stuffed zero is still sent before the end-of-packet state.
- R7: The bit time after the final coded bit begins the end-of-packet state. In that state both outputs are low for exactly EOP_LEN (2) bit times, and the line is J immediately afterwards.
- R8: After end-of-packet, the line stays at J for GAP_LEN (1) bit time before a new start is honoured. With a start already waiting, exactly GAP_LEN+1 (2) J bit times separate the last low-low bit time from the first sync flip.
- R9: While idle, a bit presented with `inValid` high and `inStart` low is accepted (`inReady`=1) and discarded, and the line stays at J.
- R10: `dPlus` and `dMinus` are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one cycle per bit time |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A packet bit is presented |
| inBit | input | 1 | Packet bit value |
| inStart | input | 1 | Presented bit is the first of a packet |
| inLast | input | 1 | Presented bit is the final one of a packet |
| inReady | output | 1 | Presented bit is taken at this clock edge |
| dPlus | output | 1 | Positive line of the pair |
| dMinus | output | 1 | Negative line of the pair |

## Verification
The assertions check, on every clock, properties that hold whatever the packet content. The pair never shows both lines high. The low-low state lasts exactly two bit times and gives way to J. The internal ones-run never passes its limit, and the handshake is held off whenever a stuff is due. Only the bench scenarios can show that the coded line as a whole is right. For each packet it must have the correct sync shape, the correct flip or hold for each bit, and stuffs in the correct places, including a stuff that falls after the final bit. The scenarios also cover the spacing between packets sent back to back, the sync-length stall before the first bit, and the discarding of unmarked bits while idle.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_TAIL,
    ST_EOP,
    ST_GAP
  } txState_t;

  // Strobes from the sequencer to the line datapath
  typedef struct packed {
    logic shiftBit;   // put one coded bit on the line
    logic bitVal;     // value of that bit (0 flips the line)
    logic driveSe0;   // both lines low
    logic driveIdle;  // force J, clear the ones run
    logic phaseClr;   // restart the phase counter
  } txStrobe_t;

endpackage

// File: rtl/nrzi_tx_datapath.sv
module nrzi_tx_datapath
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  parameter int RUN_W     = 3,
  parameter int PH_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  output logic [PH_W-1:0]  phase,
  output logic [RUN_W-1:0] runCount,
  output logic             runFull,
  output logic             runNearFull,
  output logic             dPlus,
  output logic             dMinus
);

  logic lineJ;
  logic se0;

  // Line state, ones run and phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineJ    <= 1'b1;
      se0      <= 1'b0;
      runCount <= '0;
      phase    <= '0;
    end else begin
      phase <= strobe.phaseClr ? '0 : phase + 1'b1;
      if (strobe.driveSe0) begin
        se0 <= 1'b1;
      end else if (strobe.driveIdle) begin
        se0      <= 1'b0;
        lineJ    <= 1'b1;
        runCount <= '0;
      end else if (strobe.shiftBit) begin
        se0 <= 1'b0;
        if (!strobe.bitVal) lineJ <= ~lineJ;
        runCount <= strobe.bitVal ? runCount + 1'b1 : '0;
      end
    end
  end

  assign runFull     = (runCount == RUN_W'(STUFF_RUN));
  assign runNearFull = (runCount == RUN_W'(STUFF_RUN - 1));
  assign dPlus       = lineJ & ~se0;
  assign dMinus      = ~lineJ & ~se0;

endmodule

// File: rtl/nrzi_tx_ctrl.sv
module nrzi_tx_ctrl
  import nrzi_tx_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter int EOP_LEN  = 2,
  parameter int GAP_LEN  = 1,
  parameter int PH_W     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inBit,
  input  logic            inStart,
  input  logic            inLast,
  input  logic [PH_W-1:0] phase,
  input  logic            runFull,
  input  logic            runNearFull,
  output logic            inReady,
  output txStrobe_t       strobe
);

  txState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    inReady   = 1'b0;
    case (state)
      ST_IDLE: begin
        strobe.driveIdle = 1'b1;
        strobe.phaseClr  = 1'b1;
        inReady          = ~inStart;   // unmarked bits are drained
        if (inValid && inStart) nextState = ST_SYNC;
      end
      ST_SYNC: begin
        strobe.shiftBit = 1'b1;
        strobe.bitVal   = (phase == PH_W'(SYNC_LEN - 1));
        if (phase == PH_W'(SYNC_LEN - 1)) begin
          strobe.phaseClr = 1'b1;
          nextState       = ST_DATA;
        end
      end
      ST_DATA: begin
        strobe.phaseClr = 1'b1;
        if (runFull) begin
          strobe.shiftBit = 1'b1;
          strobe.bitVal   = 1'b0;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            strobe.shiftBit = 1'b1;
            strobe.bitVal   = inBit;
            if (inLast) nextState = (inBit && runNearFull) ? ST_TAIL : ST_EOP;
          end
        end
      end
      ST_TAIL: begin
        strobe.shiftBit = 1'b1;
        strobe.bitVal   = 1'b0;
        strobe.phaseClr = 1'b1;
        nextState       = ST_EOP;
      end
      ST_EOP: begin
        strobe.driveSe0 = 1'b1;
        if (phase == PH_W'(EOP_LEN - 1)) begin
          strobe.phaseClr = 1'b1;
          nextState       = ST_GAP;
        end
      end
      ST_GAP: begin
        strobe.driveIdle = 1'b1;
        if (phase == PH_W'(GAP_LEN - 1)) begin
          strobe.phaseClr = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  parameter int SYNC_LEN  = 8,
  parameter int EOP_LEN   = 2,
  parameter int GAP_LEN   = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  input  logic inStart,
  input  logic inLast,
  output logic inReady,
  output logic dPlus,
  output logic dMinus
);

  localparam int RUN_W  = $clog2(STUFF_RUN + 1);
  localparam int PH_MAX = (SYNC_LEN > EOP_LEN)
                        ? ((SYNC_LEN > GAP_LEN) ? SYNC_LEN : GAP_LEN)
                        : ((EOP_LEN > GAP_LEN) ? EOP_LEN : GAP_LEN);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  txStrobe_t        strobe;
  logic [PH_W-1:0]  phase;
  logic [RUN_W-1:0] runCount;
  logic             runFull;
  logic             runNearFull;

  nrzi_tx_ctrl #(
    .SYNC_LEN(SYNC_LEN), .EOP_LEN(EOP_LEN), .GAP_LEN(GAP_LEN), .PH_W(PH_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inBit(inBit), .inStart(inStart), .inLast(inLast),
    .phase(phase), .runFull(runFull), .runNearFull(runNearFull),
    .inReady(inReady), .strobe(strobe)
  );

  nrzi_tx_datapath #(
    .STUFF_RUN(STUFF_RUN), .RUN_W(RUN_W), .PH_W(PH_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .phase(phase), .runCount(runCount),
    .runFull(runFull), .runNearFull(runNearFull),
    .dPlus(dPlus), .dMinus(dMinus)
  );

endmodule

// File: rtl/nrzi_tx_checker.sv
module nrzi_tx_checker #(
  parameter int STUFF_RUN = 6,
  parameter int RUN_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             dPlus,
  input logic             dMinus,
  input logic             inReady,
  input logic             runFull,
  input logic [RUN_W-1:0] runCount
);

  logic se0Now;
  logic jNow;
  assign se0Now = ~dPlus & ~dMinus;
  assign jNow   = dPlus & ~dMinus;

  AST_PAIR_NOT_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !(dPlus && dMinus)); // R10

  AST_SE0_TWO_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(se0Now) |=> se0Now); // R7

  AST_SE0_THEN_J: assert property (@(posedge clk) disable iff (!rstN)
    (se0Now && $past(se0Now)) |=> jNow); // R7

  AST_STUFF_STALLS_READY: assert property (@(posedge clk) disable iff (!rstN)
    runFull |-> !inReady); // R5

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= RUN_W'(STUFF_RUN)); // R4

endmodule

bind nrzi_stuff_tx nrzi_tx_checker #(
  .STUFF_RUN(STUFF_RUN), .RUN_W(RUN_W)
) i_checker (
  .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus),
  .inReady(inReady), .runFull(runFull), .runCount(runCount)
);

// File: tb/test_nrzi_stuff_tx.sv
module test_nrzi_stuff_tx;

  localparam logic [1:0] SYM_J   = 2'b10;
  localparam logic [1:0] SYM_K   = 2'b01;
  localparam logic [1:0] SYM_SE0 = 2'b00;
  localparam int NVEC = 8;

  // {data (LSB sent first), bit count, expected stuffed bits}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h000000A5, 8'd8,  8'd0},
    {32'h000000FF, 8'd8,  8'd1},
    {32'h0000FFFF, 8'd16, 8'd2},
    {32'h0000001F, 8'd5,  8'd1},  // last bit completes the run
    {32'h00000000, 8'd8,  8'd0},
    {32'h0000007E, 8'd8,  8'd1},
    {32'h00000001, 8'd1,  8'd0},
    {32'h00000FC0, 8'd12, 8'd1}   // zeros then six ones ending the packet
  };

  logic clk = 1'b0;
  logic rstN, inValid, inBit, inStart, inLast;
  logic inReady, dPlus, dMinus;

  int errors = 0;
  int checks = 0;

  logic [1:0] expSym [128];
  logic [1:0] capSym [128];
  int expN, capN, leadJ, waitN;
  bit mLine;
  int mRun;

  always #10 clk = ~clk;

  nrzi_stuff_tx i_nrzi_stuff_tx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .inStart(inStart), .inLast(inLast), .inReady(inReady),
    .dPlus(dPlus), .dMinus(dMinus)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference coder built from the requirements
  function automatic void pushRaw(input bit b);
    if (!b) mLine = ~mLine;
    mRun = b ? mRun + 1 : 0;
    expSym[expN] = mLine ? SYM_J : SYM_K;
    expN++;
  endfunction

  function automatic void pushBit(input bit b);
    pushRaw(b);
    if (mRun == 6) pushRaw(1'b0);
  endfunction

  function automatic void buildExp(input logic [31:0] d, input int n);
    mLine = 1'b1; mRun = 0; expN = 0;
    for (int k = 0; k < 8; k++) pushBit(k == 7);
    for (int i = 0; i < n; i++) pushBit(d[i]);
    expSym[expN] = SYM_SE0; expN++;
    expSym[expN] = SYM_SE0; expN++;
    expSym[expN] = SYM_J;   expN++;
  endfunction

  task automatic driveBits(input logic [31:0] d, input int n);
    int i = 0;
    bit acc;
    bit first = 1'b1;
    waitN = 0;
    inValid = 1'b1; inStart = 1'b1; inBit = d[0]; inLast = (n == 1);
    while (i < n) begin
      #1 acc = inReady;
      if (!acc && first) waitN++;
      @(negedge clk);
      if (acc) begin
        first = 1'b0;
        i++;
        inStart = 1'b0;
        if (i < n) begin
          inBit = d[i]; inLast = (i == n - 1);
        end else begin
          inValid = 1'b0; inLast = 1'b0; inBit = 1'b0;
        end
      end
    end
  endtask

  task automatic captureLine();
    logic [1:0] s;
    bit seenSe0 = 1'b0;
    capN = 0; leadJ = 0;
    @(negedge clk); s = {dPlus, dMinus};
    while (s == SYM_J) begin
      leadJ++;
      @(negedge clk); s = {dPlus, dMinus};
    end
    while (1) begin
      if (capN < 128) capSym[capN] = s;
      capN++;
      if (seenSe0 && s == SYM_J) break;
      if (s == SYM_SE0) seenSe0 = 1'b1;
      @(negedge clk); s = {dPlus, dMinus};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inBit = 1'b0; inStart = 1'b0; inLast = 1'b0;
    repeat (3) @(negedge clk);
    check({dPlus, dMinus} == SYM_J, "R1", "line in reset", {dPlus, dMinus}, SYM_J);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({dPlus, dMinus} == SYM_J, "R1", "idle line", {dPlus, dMinus}, SYM_J);

    // R9: unmarked bits while idle are drained and ignored
    inValid = 1'b1; inStart = 1'b0; inBit = 1'b0;
    #1 check(inReady == 1'b1, "R9", "ready for unmarked idle bit", inReady, 1);
    repeat (4) @(negedge clk);
    check({dPlus, dMinus} == SYM_J, "R9", "line after drained bits", {dPlus, dMinus}, SYM_J);
    inValid = 1'b0;
    @(negedge clk);

    // Table walk, packets sent back to back
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] d;
      int n, st, k;
      d = VEC[v][47:16]; n = int'(VEC[v][15:8]); st = int'(VEC[v][7:0]);
      buildExp(d, n);
      fork
        driveBits(d, n);
        captureLine();
      join
      // R2: start bit held through idle + sync cycles
      check(waitN == 9, "R2", "stall before first bit", waitN, 9);
      // R3 R4 R6 R7: complete line picture
      check(capN == expN, "R3", "coded length", capN, expN);
      k = 0;
      while (k < expN && k < capN && capSym[k] == expSym[k]) k++;
      check(k == expN, "R4", "first mismatching symbol index", k, expN);
      if (k < expN && k < capN)
        $display("  vector %0d symbol %0d: actual=%b expected=%b", v, k, capSym[k], expSym[k]);
      // R5 R6: number of inserted bits
      check(capN - n - 11 == st, (v == 3 || v == 7) ? "R6" : "R5", "stuffed bits",
            capN - n - 11, st);
      // R8: minimum spacing between packets
      if (v > 0) check(leadJ == 1, "R8", "extra J bit times before sync", leadJ, 1);
    end

    repeat (3) @(negedge clk);
    check({dPlus, dMinus} == SYM_J, "R7", "line rests at J after end", {dPlus, dMinus}, SYM_J);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule